// File: doc/BRIEF.md
# ADC Start-Request Generator with Buffered Compare

This block watches the count value of a PWM timer and raises a one-cycle start request for an analog-to-digital converter when the count equals an active compare value. Software never writes the active compare value directly. It writes a buffer register, and the buffer is copied into the active register only at a timing point chosen in the control word. In triangle-wave (complementary PWM) mode that point is the counter peak, the counter valley, both, or neither. In every other mode the copy happens on the timer's period compare match, and only while the timing field is zero.

Start requests can also be tied to a skip counter. The skip counter counts selected peak and valley events and opens a trigger window once every N events. When the link is on, a request passes only while that window is open. The timer counter and the converter are outside this block.

The skip logic is a three-state machine. SK_OFF means skipping is disabled. SK_WAIT means events are being counted. SK_OPEN means the count has been reached and the window is open. The transitions are:
- any state → SK_OFF on a control write or when skipping is disabled;
- SK_OFF → SK_WAIT once skipping is enabled;
- SK_WAIT → SK_OPEN when a counted event brings the count to N;
- SK_OPEN → SK_WAIT on the next counted event when N > 1;
- SK_OPEN → SK_OPEN on that event when N = 1.

Top module: `adc_trig_gen`

## Requirements
- R1: After reset the buffer, the active compare value, all control fields and the skip count are zero, and `adc_start` stays low.
- R2: The control register (`reg_sel`=0) is written only when `reg_be`=2'b11. A write with any other byte enable leaves every control field unchanged. Field layout: [1:0] transfer timing, [2] up-count trigger enable, [3] down-count trigger enable, [4] skip link, [5] count peak events, [6] count valley events, [10:8] skip count N.
- R3: The buffer register (`reg_sel`=1) accepts byte-lane writes: bit 0 of `reg_be` selects data bits [7:0] and bit 1 selects bits [15:8]. The active compare value changes only on a transfer event.
- R4: With `cmpl_mode`=1 the timing field selects the transfer point: 00 gives no transfer, 01 the peak (`crest_evt`), 10 the valley (`trough_evt`), 11 both. `period_match` causes no transfer.
- R5: With `cmpl_mode`=0 the buffer transfers on `period_match` only while the timing field is 00. A nonzero timing field blocks every transfer. Peak and valley pulses cause no transfer.
- R6: A buffer write in the same cycle as a transfer event puts the newly written value into the active register.
- R7: When `cnt_val` first equals the active value while counting in an enabled direction (`cnt_up`=1 uses bit 2, `cnt_up`=0 uses bit 3), `adc_start` is high for exactly one cycle in the following cycle. It stays low while the match is held.
- R8: In complementary mode each peak or valley event whose count bit is set increments the skip count. The event that makes the count equal N opens the window and reloads the count to zero. The window stays open until the next counted event, so it is open after every N-th counted event.
- R9: With the link set, a request is issued only while the window is open. If skipping is disabled (both count bits clear or N=0), no request is issued at all.
- R10: With the link clear, requests are issued regardless of the skip state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects control, 1 selects buffer |
| reg_be | input | 2 | Byte enables for the write |
| reg_wdata | input | 16 | Write data |
| cnt_val | input | CNT_W | Timer count value |
| cnt_up | input | 1 | 1 while the timer counts up |
| cmpl_mode | input | 1 | 1 selects triangle-wave (complementary PWM) mode |
| crest_evt | input | 1 | One-cycle pulse at the counter peak |
| trough_evt | input | 1 | One-cycle pulse at the counter valley |
| period_match | input | 1 | One-cycle pulse on the timer's period compare match |
| adc_start | output | 1 | One-cycle converter start request |

## Verification
The assertions assume that `crest_evt`, `trough_evt` and `period_match` are single-cycle pulses, and that the mode and direction inputs only change between events. The stimulus raises each event for exactly one clock and changes `cmpl_mode` and `cnt_up` only in idle cycles. After every control write the bench waits one extra cycle before sending counted events, because the skip machine restarts through SK_OFF. Active compare values are always kept below 0x8000, so the "away" count value used between probes can never match.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
    localparam int SKIP_W = 3;

    typedef enum logic [1:0] {
        SK_OFF  = 2'd0,
        SK_WAIT = 2'd1,
        SK_OPEN = 2'd2
    } skip_st_e;

    typedef struct packed {
        logic [1:0]        xfer_sel;
        logic              up_en;
        logic              dn_en;
        logic              link_en;
        logic              sk_crest;
        logic              sk_trough;
        logic [SKIP_W-1:0] sk_cnt;
    } ctrl_t;
endpackage

// File: rtl/adc_trig_regs.sv
module adc_trig_regs
    import adc_trig_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic                reg_sel,
    input  logic [1:0]          reg_be,
    input  logic [15:0]         reg_wdata,
    input  logic                cmpl_mode,
    input  logic                crest_evt,
    input  logic                trough_evt,
    input  logic                period_match,
    output logic                ctrl_wr,
    output logic                up_en,
    output logic                dn_en,
    output logic                link_en,
    output logic                sk_crest,
    output logic                sk_trough,
    output logic [SKIP_W-1:0]   sk_cnt,
    output logic [CNT_W-1:0]    active_cmp
);
    localparam int LANES = 2;

    ctrl_t       ctrl_q;
    logic [15:0] buf_q;
    logic [15:0] buf_nxt;
    logic        xfer;
    logic        ctl_unused_bits;

    assign ctl_unused_bits = ^{reg_wdata[15:11], reg_wdata[7]};
    assign ctrl_wr = reg_wr && !reg_sel && (reg_be == 2'b11);

    always_comb begin
        buf_nxt = buf_q;
        for (int i = 0; i < LANES; i++) begin
            if (reg_wr && reg_sel && reg_be[i])
                buf_nxt[8*i +: 8] = reg_wdata[8*i +: 8];
        end
    end

    always_comb begin
        if (cmpl_mode)
            xfer = (ctrl_q.xfer_sel[0] && crest_evt) || (ctrl_q.xfer_sel[1] && trough_evt);
        else
            xfer = period_match && (ctrl_q.xfer_sel == 2'b00);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q     <= '0;
            buf_q      <= '0;
            active_cmp <= '0;
        end else begin
            buf_q <= buf_nxt;
            if (ctrl_wr) begin
                ctrl_q.xfer_sel  <= reg_wdata[1:0];
                ctrl_q.up_en     <= reg_wdata[2];
                ctrl_q.dn_en     <= reg_wdata[3];
                ctrl_q.link_en   <= reg_wdata[4];
                ctrl_q.sk_crest  <= reg_wdata[5];
                ctrl_q.sk_trough <= reg_wdata[6];
                ctrl_q.sk_cnt    <= reg_wdata[8 +: SKIP_W];
            end
            if (xfer)
                active_cmp <= buf_nxt[CNT_W-1:0];
        end
    end

    assign up_en     = ctrl_q.up_en;
    assign dn_en     = ctrl_q.dn_en;
    assign link_en   = ctrl_q.link_en;
    assign sk_crest  = ctrl_q.sk_crest;
    assign sk_trough = ctrl_q.sk_trough;
    assign sk_cnt    = ctrl_q.sk_cnt;

    // R2: partial-width control writes leave the control word alone
    p_byte_ctrl_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_sel && reg_be != 2'b11) |=> $stable(ctrl_q));

    // R4: timing field 00 in complementary mode never reloads
    p_no_xfer_when_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl_mode && ctrl_q.xfer_sel == 2'b00) |=> $stable(active_cmp));

    // R5: nonzero timing field outside complementary mode is inert
    p_prohibited_setting_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmpl_mode && ctrl_q.xfer_sel != 2'b00) |=> $stable(active_cmp));

    // R3: no event of any kind means no reload
    p_hold_without_event_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!crest_evt && !trough_evt && !period_match) |=> $stable(active_cmp));
endmodule

// File: rtl/adc_trig_skip.sv
module adc_trig_skip
    import adc_trig_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic              cmpl_mode,
    input  logic              crest_evt,
    input  logic              trough_evt,
    input  logic              sk_crest,
    input  logic              sk_trough,
    input  logic [SKIP_W-1:0] sk_cnt,
    output logic              sk_open
);
    skip_st_e          st_q, st_d;
    logic [SKIP_W-1:0] cnt_q, cnt_d;
    logic [SKIP_W-1:0] cnt_inc;
    logic              sk_enabled;
    logic              sk_evt;

    assign sk_enabled = (sk_crest || sk_trough) && (sk_cnt != '0);
    assign sk_evt     = cmpl_mode && ((sk_crest && crest_evt) || (sk_trough && trough_evt));
    assign cnt_inc    = cnt_q + SKIP_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= SK_OFF;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (ctrl_wr || !sk_enabled) begin
            st_d  = SK_OFF;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                SK_OFF: begin
                    st_d  = SK_WAIT;
                    cnt_d = '0;
                end
                SK_WAIT, SK_OPEN: begin
                    if (sk_evt) begin
                        if (cnt_inc == sk_cnt) begin
                            st_d  = SK_OPEN;
                            cnt_d = '0;
                        end else begin
                            st_d  = SK_WAIT;
                            cnt_d = cnt_inc;
                        end
                    end
                end
                default: begin
                    st_d  = SK_OFF;
                    cnt_d = '0;
                end
            endcase
        end
    end

    always_comb begin
        sk_open = (st_q == SK_OPEN);
    end

    // R8: the running count never reaches the programmed limit
    p_cnt_below_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != SK_OFF) |-> (cnt_q < sk_cnt));

    // R8: the window opens only on a counted event
    p_open_on_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sk_open) |-> $past(sk_evt));

    // R9: disabled skipping parks the machine
    p_off_when_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !sk_enabled |=> (st_q == SK_OFF));
endmodule

// File: rtl/adc_trig_match.sv
module adc_trig_match #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_up,
    input  logic [CNT_W-1:0] active_cmp,
    input  logic             up_en,
    input  logic             dn_en,
    input  logic             link_en,
    input  logic             sk_open,
    output logic             adc_start
);
    logic hit;
    logic hit_q;
    logic gate;

    assign hit  = (cnt_val == active_cmp) && (cnt_up ? up_en : dn_en);
    assign gate = link_en ? sk_open : 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q     <= 1'b0;
            adc_start <= 1'b0;
        end else begin
            hit_q     <= hit;
            adc_start <= hit && !hit_q && gate;
        end
    end

    // R7: a request never lasts two cycles
    p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start);

    // R7: a direction with its enable clear never triggers
    p_dir_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_up && !dn_en) |=> !adc_start);

    // R9: linked requests wait for the skip window
    p_link_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (link_en && !sk_open) |=> !adc_start);
endmodule

// File: rtl/adc_trig_gen.sv
module adc_trig_gen
    import adc_trig_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [1:0]       reg_be,
    input  logic [15:0]      reg_wdata,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_up,
    input  logic             cmpl_mode,
    input  logic             crest_evt,
    input  logic             trough_evt,
    input  logic             period_match,
    output logic             adc_start
);
    logic              ctrl_wr;
    logic              up_en;
    logic              dn_en;
    logic              link_en;
    logic              sk_crest;
    logic              sk_trough;
    logic [SKIP_W-1:0] sk_cnt;
    logic [CNT_W-1:0]  active_cmp;
    logic              sk_open;

    adc_trig_regs #(.CNT_W(CNT_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_be(reg_be), .reg_wdata(reg_wdata), .cmpl_mode(cmpl_mode),
        .crest_evt(crest_evt), .trough_evt(trough_evt), .period_match(period_match),
        .ctrl_wr(ctrl_wr), .up_en(up_en), .dn_en(dn_en), .link_en(link_en),
        .sk_crest(sk_crest), .sk_trough(sk_trough), .sk_cnt(sk_cnt),
        .active_cmp(active_cmp)
    );

    adc_trig_skip skip_i (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .cmpl_mode(cmpl_mode),
        .crest_evt(crest_evt), .trough_evt(trough_evt), .sk_crest(sk_crest),
        .sk_trough(sk_trough), .sk_cnt(sk_cnt), .sk_open(sk_open)
    );

    adc_trig_match #(.CNT_W(CNT_W)) match_i (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_up(cnt_up),
        .active_cmp(active_cmp), .up_en(up_en), .dn_en(dn_en),
        .link_en(link_en), .sk_open(sk_open), .adc_start(adc_start)
    );

    // R1: nothing fires in the first cycle out of reset
    p_quiet_after_reset_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> !adc_start);
endmodule

// File: tb/adc_trig_gen_tb_top.sv
module adc_trig_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr, reg_sel;
    logic [1:0]  reg_be;
    logic [15:0] reg_wdata;
    logic [15:0] cnt_val;
    logic        cnt_up, cmpl_mode, crest_evt, trough_evt, period_match;
    logic        adc_start;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [15:0] mdl_act;

    always #2 clk = ~clk;

    adc_trig_gen dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_be(reg_be), .reg_wdata(reg_wdata), .cnt_val(cnt_val),
        .cnt_up(cnt_up), .cmpl_mode(cmpl_mode), .crest_evt(crest_evt),
        .trough_evt(trough_evt), .period_match(period_match), .adc_start(adc_start)
    );

    function automatic logic [15:0] mk_ctrl(input logic [1:0] xs, input logic up,
        input logic dn, input logic lk, input logic sc, input logic st, input logic [2:0] n);
        return {5'b0, n, 1'b0, st, sc, lk, dn, up, xs};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [1:0] be, input logic [15:0] d);
        reg_wr = 1'b1; reg_sel = sel; reg_be = be; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic evt(input logic c, input logic t, input logic p);
        crest_evt = c; trough_evt = t; period_match = p;
        @(negedge clk);
        crest_evt = 1'b0; trough_evt = 1'b0; period_match = 1'b0;
    endtask

    task automatic probe(input logic [15:0] v, input logic exp, input string req);
        cnt_val = v ^ 16'h8000;
        @(negedge clk);
        cnt_val = v;
        @(negedge clk);
        chk(req, {31'd0, adc_start}, {31'd0, exp});
        cnt_val = v ^ 16'h8000;
        @(negedge clk);
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R1 watchdog actual=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; reg_wr = 1'b0; reg_sel = 1'b0; reg_be = 2'b00; reg_wdata = '0;
        cnt_val = '0; cnt_up = 1'b1; cmpl_mode = 1'b0;
        crest_evt = 1'b0; trough_evt = 1'b0; period_match = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: count 0 equals cleared active value but enables are clear
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R1 quiet after reset", {31'd0, adc_start}, 32'd0);
        end
        wr(1'b0, 2'b11, mk_ctrl(2'b00, 1, 0, 0, 0, 0, 3'd0));
        probe(16'h0000, 1'b1, "R1 active cleared to zero");
        mdl_act = 16'h0000;

        // R2: byte writes to control are dropped
        wr(1'b0, 2'b01, 16'h0000);
        probe(16'h0000, 1'b1, "R2 low-byte write ignored");
        wr(1'b0, 2'b10, 16'h0000);
        probe(16'h0000, 1'b1, "R2 high-byte write ignored");

        // R3: buffer write alone, then lane writes
        wr(1'b1, 2'b11, 16'h0123);
        probe(16'h0000, 1'b1, "R3 active held without event");
        probe(16'h0123, 1'b0, "R3 buffer not yet active");
        wr(1'b1, 2'b01, 16'h33AA);
        wr(1'b1, 2'b10, 16'h55CC);
        evt(0, 0, 1);
        mdl_act = 16'h55AA;
        probe(16'h55AA, 1'b1, "R3 byte lanes merged");

        // R4/R5 sweep: mode x timing field x event kind
        for (int cm = 0; cm < 2; cm++) begin
            for (int xs = 0; xs < 4; xs++) begin
                for (int ev = 0; ev < 3; ev++) begin
                    logic [15:0] nv;
                    logic        ex;
                    nv = 16'h0200 + 16'((cm * 12 + xs * 3 + ev) * 16);
                    if (cm == 1)
                        ex = (ev == 0 && xs[0]) || (ev == 1 && xs[1]);
                    else
                        ex = (ev == 2 && xs == 0);
                    cmpl_mode = cm[0];
                    wr(1'b0, 2'b11, mk_ctrl(xs[1:0], 1, 0, 0, 0, 0, 3'd0));
                    wr(1'b1, 2'b11, nv);
                    evt(ev == 0, ev == 1, ev == 2);
                    if (ex) mdl_act = nv;
                    if (cm == 1) begin
                        probe(nv, ex, "R4 transfer point");
                        probe(mdl_act, 1'b1, "R4 active value");
                    end else begin
                        probe(nv, ex, "R5 period-match transfer");
                        probe(mdl_act, 1'b1, "R5 active value");
                    end
                end
            end
        end

        // R6: write and transfer in one cycle
        cmpl_mode = 1'b1;
        wr(1'b0, 2'b11, mk_ctrl(2'b01, 1, 0, 0, 0, 0, 3'd0));
        reg_wr = 1'b1; reg_sel = 1'b1; reg_be = 2'b11; reg_wdata = 16'h0777;
        crest_evt = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; crest_evt = 1'b0;
        mdl_act = 16'h0777;
        probe(16'h0777, 1'b1, "R6 same-cycle write carried");

        // R7: direction enables and pulse width
        wr(1'b0, 2'b11, mk_ctrl(2'b00, 1, 0, 0, 0, 0, 3'd0));
        cnt_up = 1'b0;
        probe(mdl_act, 1'b0, "R7 down count disabled");
        wr(1'b0, 2'b11, mk_ctrl(2'b00, 0, 1, 0, 0, 0, 3'd0));
        probe(mdl_act, 1'b1, "R7 down count enabled");
        cnt_up = 1'b1;
        probe(mdl_act, 1'b0, "R7 up count disabled");
        wr(1'b0, 2'b11, mk_ctrl(2'b00, 1, 0, 0, 0, 0, 3'd0));
        cnt_val = mdl_act;
        @(negedge clk);
        chk("R7 pulse first cycle", {31'd0, adc_start}, 32'd1);
        @(negedge clk);
        chk("R7 pulse ends while match held", {31'd0, adc_start}, 32'd0);
        cnt_val = mdl_act ^ 16'h8000;
        @(negedge clk);

        // R8: skip window every N counted peaks; valleys not counted
        for (int s = 1; s <= 4; s++) begin
            wr(1'b0, 2'b11, mk_ctrl(2'b00, 1, 0, 1, 1, 0, 3'(s)));
            @(negedge clk);
            for (int k = 1; k <= 2 * s + 1; k++) begin
                evt(0, 1, 0);
                evt(1, 0, 0);
                probe(mdl_act, (k % s) == 0, "R8 skip window");
            end
        end

        // R9: link with skipping disabled
        wr(1'b0, 2'b11, mk_ctrl(2'b00, 1, 0, 1, 1, 0, 3'd0));
        @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            evt(1, 0, 0);
            probe(mdl_act, 1'b0, "R9 link with zero skip count");
        end
        wr(1'b0, 2'b11, mk_ctrl(2'b00, 1, 0, 1, 0, 0, 3'd3));
        @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            evt(1, 1, 0);
            probe(mdl_act, 1'b0, "R9 link with no event source");
        end

        // R10: link clear ignores the skip state
        wr(1'b0, 2'b11, mk_ctrl(2'b00, 1, 0, 0, 1, 0, 3'd3));
        @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            evt(1, 0, 0);
            probe(mdl_act, 1'b1, "R10 unlinked request");
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule